// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a small processor subsystem may drop into a standby-class low-power state and when it has to come back out. Software arms it with a deep-sleep enable and a mode code. Entry then comes from one of two places: a wait-for-interrupt or wait-for-event request, or the return from an interrupt handler while sleep-on-exit is armed. Each path has its own gating. Still-set wake-up pin flags block entry on both paths. The handler-return path is also blocked by supply-monitor, radio, timer and tamper flags that are still set.

A three-state sequencer (RUN, ENTERING, LOWPOWER) applies the request. The single ENTERING cycle re-tests every gate and falls back to RUN if any gate has changed. While the block is in low power, the regulator and oscillator enables are dropped and the pad pull settings are driven onto the pads. Mode codes 3'b100 and above select the deepest variant. In that variant the brown-out monitor is also off, and leaving it pulses a retention-clear and wipes the stored pull settings, as a power-on reset would. A sticky wake-cause register records the first wake source, and software clears it by writing ones.

Wake-up pins pass through a two-stage synchronizer. An edge of the selected polarity sets a sticky per-pin flag, which software also clears by writing ones.

Top module: `lpm_ctrl`

## Requirements
- R1: With deep_en set and mode_sel >= 3'b011, a wfi_req pulse while irq_pend is low makes lp_active rise after the second rising edge. A pending interrupt blocks this path and a pending event does not.
- R2: A wfe_req pulse enters in the same way while evt_pend is low. A pending event blocks this path and a pending interrupt does not. With deep_en low, neither path nor the handler-return path enters.
- R3: An isr_ret pulse enters only with exit_on_ret set, irq_pend low and all of these clear: pvd_flag, rfbusy_flag, rf_irq, timer_flag, every tamp_flag bit.
- R4: No path enters with mode_sel below 3'b011. A mode_sel of 3'b100 or higher at entry makes lp_deep high for the whole low-power stay.
- R5: No path enters while any pin_flag bit is set.
- R6: If a gate of the chosen path fails during the ENTERING cycle, the block returns to RUN and lp_active stays low.
- R7: A pin with pin_en set raises its pin_flag bit on a rising edge when its pin_pol bit is 0 and on a falling edge when it is 1. The opposite edge has no effect. The flag is set within four cycles of the pad change and is cleared by writing 1 to pin_clr.
- R8: In low power, any set pin flag, timer_evt, tamp_evt, ext_rst, wdg_rst or bor_rst returns the block to RUN at the next rising edge. In the deep variant bor_rst is ignored.
- R9: On exit, if wake_cause is zero, it records exactly one bit: the lowest-indexed active source. Bits 0..NPIN-1 are the pins, followed in order by timer, tamper, reset pin, watchdog and brown-out (bits 3..7 for three pins). A nonzero wake_cause is kept until software writes 1s to wc_clr.
- R10: reg_en and osc_en are low exactly while lp_active is high. bor_en is low exactly while lp_deep is high.
- R11: cfg_we stores pull-up and pull-down nibbles for bank cfg_bank. The pads carry them only in low power, with pull-up winning over pull-down. At all other times pad_pu and pad_pd are zero.
- R12: Leaving the deep variant pulses ret_clr high for exactly one cycle and erases every stored pull setting. Leaving standby keeps the settings and leaves ret_clr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| wfe_req | input | 1 | Wait-for-event request strobe |
| isr_ret | input | 1 | Return-from-handler strobe |
| deep_en | input | 1 | Deep-sleep enable |
| exit_on_ret | input | 1 | Sleep-on-exit enable |
| mode_sel | input | MODE_W | Low-power mode code |
| irq_pend | input | 1 | Interrupt pending |
| evt_pend | input | 1 | Event pending |
| pvd_flag | input | 1 | Supply-monitor wake flag |
| rfbusy_flag | input | 1 | Radio-busy wake flag |
| rf_irq | input | 1 | Radio interrupt |
| timer_flag | input | 1 | Selected timer flag |
| tamp_flag | input | NTAMP | Tamper flags |
| pin_in | input | NPIN | Wake-up pads, asynchronous |
| pin_en | input | NPIN | Per-pin wake enable |
| pin_pol | input | NPIN | Edge select, 1 = falling |
| pin_clr | input | NPIN | Write-1-to-clear for pin_flag |
| timer_evt | input | 1 | Timer wake event |
| tamp_evt | input | 1 | Tamper wake event |
| ext_rst | input | 1 | Reset pin request |
| wdg_rst | input | 1 | Watchdog reset request |
| bor_rst | input | 1 | Brown-out reset request |
| cfg_we | input | 1 | Pull-setting write strobe |
| cfg_bank | input | BANK_W | Bank index for the write |
| cfg_pu | input | PADW | Pull-up bits for the bank |
| cfg_pd | input | PADW | Pull-down bits for the bank |
| wc_clr | input | NCAUSE | Write-1-to-clear for wake_cause |
| reg_en | output | 1 | Regulator enable |
| osc_en | output | 1 | Oscillator enable |
| bor_en | output | 1 | Brown-out monitor enable |
| ret_clr | output | 1 | Retention-clear pulse |
| lp_active | output | 1 | In low power |
| lp_deep | output | 1 | In the deep variant |
| pad_pu | output | NBANK*PADW | Pad pull-ups, bank-major |
| pad_pd | output | NBANK*PADW | Pad pull-downs, bank-major |
| pin_flag | output | NPIN | Sticky wake-pin flags |
| wake_cause | output | NCAUSE | Sticky one-hot wake cause |

## Verification
The bench builds the block with its defaults: three wake pins, three tamper flags, three pad banks of four pads and a 3-bit mode code. This small setup lets it sweep all eight mode codes against all three entry paths. It also tries every handler-return blocker one at a time and drives each non-pin wake source in both standby and deep. Because there are only three pins and three banks, it can also cover each edge polarity, both abort causes in ENTERING, and the keep-versus-wipe behaviour of the pull settings across both kinds of exit.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NPIN = 3,
  parameter int NTAMP = 3,
  parameter int NBANK = 3,
  parameter int PADW = 4,
  parameter int MODE_W = 3,
  parameter int STBY_MODE = 3,
  parameter int DEEP_MODE = 4,
  localparam int NCAUSE = NPIN + 5,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int PADS = NBANK * PADW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfi_req,
  input  logic              wfe_req,
  input  logic              isr_ret,
  input  logic              deep_en,
  input  logic              exit_on_ret,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              irq_pend,
  input  logic              evt_pend,
  input  logic              pvd_flag,
  input  logic              rfbusy_flag,
  input  logic              rf_irq,
  input  logic              timer_flag,
  input  logic [NTAMP-1:0]  tamp_flag,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   pin_en,
  input  logic [NPIN-1:0]   pin_pol,
  input  logic [NPIN-1:0]   pin_clr,
  input  logic              timer_evt,
  input  logic              tamp_evt,
  input  logic              ext_rst,
  input  logic              wdg_rst,
  input  logic              bor_rst,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [PADW-1:0]   cfg_pu,
  input  logic [PADW-1:0]   cfg_pd,
  input  logic [NCAUSE-1:0] wc_clr,
  output logic              reg_en,
  output logic              osc_en,
  output logic              bor_en,
  output logic              ret_clr,
  output logic              lp_active,
  output logic              lp_deep,
  output logic [PADS-1:0]   pad_pu,
  output logic [PADS-1:0]   pad_pd,
  output logic [NPIN-1:0]   pin_flag,
  output logic [NCAUSE-1:0] wake_cause
);

  typedef enum logic [1:0] {S_RUN, S_ENT, S_LP} st_t;
  typedef enum logic [1:0] {P_WFI, P_WFE, P_RET} path_t;

  st_t   st;
  path_t path_q;
  logic  deep_q;

  logic mode_ok, pins_idle, ret_idle;
  logic gate_wfi, gate_wfe, gate_ret, gate_hold;

  assign mode_ok   = mode_sel >= MODE_W'(STBY_MODE);
  assign pins_idle = ~|pin_flag;
  assign ret_idle  = ~pvd_flag & ~rfbusy_flag & ~rf_irq & ~timer_flag & ~|tamp_flag;
  assign gate_wfi  = deep_en & ~irq_pend;
  assign gate_wfe  = deep_en & ~evt_pend;
  assign gate_ret  = deep_en & exit_on_ret & ~irq_pend & ret_idle;

  always_comb begin
    unique case (path_q)
      P_WFI:   gate_hold = gate_wfi;
      P_WFE:   gate_hold = gate_wfe;
      default: gate_hold = gate_ret;
    endcase
  end

  logic [NPIN-1:0] sy1, sy2, sy3, pin_hit;

  assign pin_hit = pin_en & ((~pin_pol & sy2 & ~sy3) | (pin_pol & ~sy2 & sy3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1      <= '0;
      sy2      <= '0;
      sy3      <= '0;
      pin_flag <= '0;
    end else begin
      sy1      <= pin_in;
      sy2      <= sy1;
      sy3      <= sy2;
      pin_flag <= (pin_flag & ~pin_clr) | pin_hit;
    end
  end

  logic [NCAUSE-1:0] wake_src, wake_pick;
  logic in_lp, wake_now, exit_deep;

  assign in_lp     = st == S_LP;
  assign wake_src  = {bor_rst & ~deep_q, wdg_rst, ext_rst, tamp_evt, timer_evt, pin_flag};
  assign wake_pick = wake_src & (~wake_src + NCAUSE'(1));
  assign wake_now  = in_lp & |wake_src;
  assign exit_deep = wake_now & deep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      path_q <= P_WFI;
      deep_q <= 1'b0;
    end else begin
      unique case (st)
        S_RUN: begin
          if (mode_ok && pins_idle) begin
            if (wfi_req && gate_wfi) begin
              path_q <= P_WFI;
              st     <= S_ENT;
            end else if (wfe_req && gate_wfe) begin
              path_q <= P_WFE;
              st     <= S_ENT;
            end else if (isr_ret && gate_ret) begin
              path_q <= P_RET;
              st     <= S_ENT;
            end
          end
        end
        S_ENT: begin
          if (mode_ok && pins_idle && gate_hold) begin
            st     <= S_LP;
            deep_q <= mode_sel >= MODE_W'(DEEP_MODE);
          end else begin
            st <= S_RUN;
          end
        end
        S_LP: if (wake_now) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cause <= '0;
      ret_clr    <= 1'b0;
    end else begin
      ret_clr <= exit_deep;
      if (wake_now && wake_cause == '0) wake_cause <= wake_pick;
      else wake_cause <= wake_cause & ~wc_clr;
    end
  end

  logic [PADW-1:0] pu_q [NBANK];
  logic [PADW-1:0] pd_q [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        pu_q[b] <= '0;
        pd_q[b] <= '0;
      end
    end else if (exit_deep) begin
      for (int b = 0; b < NBANK; b++) begin
        pu_q[b] <= '0;
        pd_q[b] <= '0;
      end
    end else if (cfg_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (cfg_bank == BANK_W'(b)) begin
          pu_q[b] <= cfg_pu;
          pd_q[b] <= cfg_pd;
        end
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_pad
    assign pad_pu[b*PADW +: PADW] = in_lp ? pu_q[b] : '0;
    assign pad_pd[b*PADW +: PADW] = in_lp ? (pd_q[b] & ~pu_q[b]) : '0;
  end

  assign lp_active = in_lp;
  assign lp_deep   = in_lp & deep_q;
  assign reg_en    = ~in_lp;
  assign osc_en    = ~in_lp;
  assign bor_en    = ~(in_lp & deep_q);

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NPIN = 3,
  parameter int NBANK = 3,
  parameter int PADW = 4,
  parameter int MODE_W = 3,
  parameter int STBY_MODE = 3,
  localparam int NCAUSE = NPIN + 5,
  localparam int PADS = NBANK * PADW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_sel,
  input logic [NPIN-1:0]   pin_flag,
  input logic              lp_active,
  input logic              lp_deep,
  input logic              reg_en,
  input logic              osc_en,
  input logic              bor_en,
  input logic              ret_clr,
  input logic [PADS-1:0]   pad_pu,
  input logic [PADS-1:0]   pad_pd,
  input logic [NCAUSE-1:0] wake_cause
);

  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active) |-> $past(mode_sel) >= MODE_W'(STBY_MODE));

  p_pin_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active) |-> $past(pin_flag) == '0);

  p_cause_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause));

  p_power_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lp_active |-> (!reg_en && !osc_en));

  p_bor_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lp_deep |-> !bor_en);

  p_pads_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_active |-> (pad_pu == '0 && pad_pd == '0));

  p_ret_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ret_clr |=> !ret_clr);

  p_ret_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_clr) |-> ($past(lp_deep) && !lp_active));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(
  .NPIN(NPIN), .NBANK(NBANK), .PADW(PADW), .MODE_W(MODE_W), .STBY_MODE(STBY_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pin_flag(pin_flag),
  .lp_active(lp_active), .lp_deep(lp_deep), .reg_en(reg_en), .osc_en(osc_en),
  .bor_en(bor_en), .ret_clr(ret_clr), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .wake_cause(wake_cause)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int NPIN = 3, NTAMP = 3, NBANK = 3, PADW = 4, MODE_W = 3;
  localparam int NCAUSE = NPIN + 5, PADS = NBANK * PADW;

  logic clk = 0, rst_n = 0;
  logic wfi_req = 0, wfe_req = 0, isr_ret = 0, deep_en = 1, exit_on_ret = 1;
  logic [MODE_W-1:0] mode_sel = 3;
  logic irq_pend = 0, evt_pend = 0, pvd_flag = 0, rfbusy_flag = 0, rf_irq = 0, timer_flag = 0;
  logic [NTAMP-1:0] tamp_flag = 0;
  logic [NPIN-1:0] pin_in = 0, pin_en = 0, pin_pol = 0, pin_clr = 0;
  logic timer_evt = 0, tamp_evt = 0, ext_rst = 0, wdg_rst = 0, bor_rst = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_bank = 0;
  logic [PADW-1:0] cfg_pu = 0, cfg_pd = 0;
  logic [NCAUSE-1:0] wc_clr = 0;
  logic reg_en, osc_en, bor_en, ret_clr, lp_active, lp_deep;
  logic [PADS-1:0] pad_pu, pad_pd;
  logic [NPIN-1:0] pin_flag;
  logic [NCAUSE-1:0] wake_cause;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req), .isr_ret(isr_ret),
    .deep_en(deep_en), .exit_on_ret(exit_on_ret), .mode_sel(mode_sel),
    .irq_pend(irq_pend), .evt_pend(evt_pend), .pvd_flag(pvd_flag),
    .rfbusy_flag(rfbusy_flag), .rf_irq(rf_irq), .timer_flag(timer_flag),
    .tamp_flag(tamp_flag), .pin_in(pin_in), .pin_en(pin_en), .pin_pol(pin_pol),
    .pin_clr(pin_clr), .timer_evt(timer_evt), .tamp_evt(tamp_evt), .ext_rst(ext_rst),
    .wdg_rst(wdg_rst), .bor_rst(bor_rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_pu(cfg_pu), .cfg_pd(cfg_pd), .wc_clr(wc_clr), .reg_en(reg_en),
    .osc_en(osc_en), .bor_en(bor_en), .ret_clr(ret_clr), .lp_active(lp_active),
    .lp_deep(lp_deep), .pad_pu(pad_pu), .pad_pd(pad_pd), .pin_flag(pin_flag),
    .wake_cause(wake_cause)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic try_enter(input int p);
    case (p)
      0: wfi_req = 1;
      1: wfe_req = 1;
      default: isr_ret = 1;
    endcase
    cyc(1);
    wfi_req = 0; wfe_req = 0; isr_ret = 0;
    cyc(1);
  endtask

  task automatic leave_and_clear();
    if (lp_active) begin
      ext_rst = 1; cyc(1); ext_rst = 0;
    end
    wc_clr = '1; cyc(1); wc_clr = 0;
    cyc(1);
  endtask

  task automatic set_blk(input int k, input logic v);
    case (k)
      0: pvd_flag = v;
      1: rfbusy_flag = v;
      2: rf_irq = v;
      3: timer_flag = v;
      4: tamp_flag[0] = v;
      5: tamp_flag[1] = v;
      6: tamp_flag[2] = v;
      7: irq_pend = v;
      default: exit_on_ret = ~v;
    endcase
  endtask

  task automatic pulse_src(input int s, input logic v);
    case (s)
      0: timer_evt = v;
      1: tamp_evt = v;
      2: ext_rst = v;
      3: wdg_rst = v;
      default: bor_rst = v;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("reset lp_active", 32'(lp_active), 0);
    chk("reset R10 power", 32'({reg_en, osc_en, bor_en}), 3'b111);
    chk("reset R9 cause", 32'(wake_cause), 0);
    chk("reset R11 pads", 32'({pad_pu, pad_pd}), 0);

    // R4 sweep: every mode code against every path
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 3; p++) begin
        mode_sel = MODE_W'(m);
        try_enter(p);
        chk($sformatf("R4 mode=%0d path=%0d entry", m, p), 32'(lp_active), 32'(m >= 3));
        chk($sformatf("R4 mode=%0d deep", m), 32'(lp_deep), 32'(m >= 4));
        chk($sformatf("R10 mode=%0d reg/osc/bor", m), 32'({reg_en, osc_en, bor_en}),
            m >= 4 ? 32'b000 : (m == 3 ? 32'b001 : 32'b111));
        if (p == 0) chk("R1 wfi entry", 32'(lp_active), 32'(m >= 3));
        if (p == 1) chk("R2 wfe entry", 32'(lp_active), 32'(m >= 3));
        if (p == 2) chk("R3 ret entry", 32'(lp_active), 32'(m >= 3));
        leave_and_clear();
      end
    end
    mode_sel = 3;

    // R1/R2 pending lines
    irq_pend = 1; try_enter(0); chk("R1 irq blocks wfi", 32'(lp_active), 0); leave_and_clear();
    try_enter(1); chk("R2 irq ignored by wfe", 32'(lp_active), 1); leave_and_clear(); irq_pend = 0;
    evt_pend = 1; try_enter(1); chk("R2 evt blocks wfe", 32'(lp_active), 0); leave_and_clear();
    try_enter(0); chk("R1 evt ignored by wfi", 32'(lp_active), 1); leave_and_clear(); evt_pend = 0;
    deep_en = 0;
    for (int p = 0; p < 3; p++) begin
      try_enter(p); chk("R2 deep_en low blocks", 32'(lp_active), 0); leave_and_clear();
    end
    deep_en = 1;

    // R3 each handler-return blocker on its own
    for (int k = 0; k < 9; k++) begin
      set_blk(k, 1);
      try_enter(2);
      chk($sformatf("R3 blocker %0d", k), 32'(lp_active), 0);
      leave_and_clear();
      set_blk(k, 0);
    end
    timer_flag = 1; try_enter(0);
    chk("R3 timer flag ignored by wfi", 32'(lp_active), 1); leave_and_clear(); timer_flag = 0;

    // R7 pin edge detection and R5 blocking
    cyc(4);
    pin_en = '1; pin_pol = 3'b010;
    pin_in[0] = 1; cyc(4);
    chk("R7 rising pin0", 32'(pin_flag), 3'b001);
    try_enter(0); chk("R5 flag blocks wfi", 32'(lp_active), 0);
    try_enter(2); chk("R5 flag blocks ret", 32'(lp_active), 0);
    pin_clr = 3'b001; cyc(1); pin_clr = 0;
    chk("R7 w1c clear", 32'(pin_flag), 0);
    pin_in[0] = 0; cyc(4);
    chk("R7 falling ignored pol0", 32'(pin_flag), 0);
    pin_in[1] = 1; cyc(4);
    chk("R7 rising ignored pol1", 32'(pin_flag), 0);
    pin_in[1] = 0; cyc(4);
    chk("R7 falling pin1", 32'(pin_flag), 3'b010);
    pin_clr = '1; cyc(1); pin_clr = 0;

    // R8/R9 pin wake
    try_enter(0); chk("R8 standby before pin", 32'(lp_active), 1);
    pin_in[2] = 1; cyc(5);
    chk("R8 pin wake", 32'(lp_active), 0);
    chk("R9 pin cause", 32'(wake_cause), 8'h04);
    pin_clr = '1; cyc(1); pin_clr = 0;
    leave_and_clear();

    // R6 abort during ENTERING
    wfi_req = 1; cyc(1); wfi_req = 0; irq_pend = 1; cyc(1);
    chk("R6 abort irq", 32'(lp_active), 0); cyc(1);
    chk("R6 abort irq stays", 32'(lp_active), 0); irq_pend = 0;
    wfe_req = 1; cyc(1); wfe_req = 0; mode_sel = 2; cyc(1);
    chk("R6 abort mode", 32'(lp_active), 0); cyc(1);
    chk("R6 abort mode stays", 32'(lp_active), 0); mode_sel = 3;

    // R8/R9/R12 every other source in standby and deep
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 5; s++) begin
        mode_sel = d ? 3'd4 : 3'd3;
        try_enter(0);
        pulse_src(s, 1); cyc(1); pulse_src(s, 0);
        chk($sformatf("R8 src=%0d deep=%0d exit", s, d), 32'(lp_active), 32'(d == 1 && s == 4));
        chk($sformatf("R9 src=%0d deep=%0d cause", s, d), 32'(wake_cause),
            (d == 1 && s == 4) ? 0 : 32'(1) << (3 + s));
        chk($sformatf("R12 src=%0d deep=%0d ret_clr", s, d), 32'(ret_clr), 32'(d == 1 && s != 4));
        cyc(1);
        chk("R12 ret_clr single", 32'(ret_clr), 0);
        leave_and_clear();
      end
    end
    mode_sel = 3;

    // R9 priority and first-seen hold
    try_enter(1);
    timer_evt = 1; wdg_rst = 1; cyc(1); timer_evt = 0; wdg_rst = 0;
    chk("R9 lowest index wins", 32'(wake_cause), 8'h08);
    try_enter(1);
    ext_rst = 1; cyc(1); ext_rst = 0;
    chk("R9 first cause kept", 32'(wake_cause), 8'h08);
    wc_clr = 8'h08; cyc(1); wc_clr = 0;
    chk("R9 w1c", 32'(wake_cause), 0);

    // R11/R12 pad settings
    cfg_we = 1; cfg_bank = 0; cfg_pu = 4'b0011; cfg_pd = 4'b0110; cyc(1);
    cfg_bank = 2; cfg_pu = 4'b0000; cfg_pd = 4'b1001; cyc(1); cfg_we = 0;
    chk("R11 pads idle in run", 32'({pad_pu, pad_pd}), 0);
    try_enter(0);
    chk("R11 pad_pu standby", 32'(pad_pu), 12'h003);
    chk("R11 pad_pd standby", 32'(pad_pd), 12'h904);
    leave_and_clear();
    chk("R11 pads off after exit", 32'({pad_pu, pad_pd}), 0);
    try_enter(0);
    chk("R12 standby keeps pu", 32'(pad_pu), 12'h003);
    chk("R12 standby keeps pd", 32'(pad_pd), 12'h904);
    leave_and_clear();
    mode_sel = 4; try_enter(0);
    chk("R11 pad_pd deep", 32'(pad_pd), 12'h904);
    ext_rst = 1; cyc(1); ext_rst = 0;
    chk("R12 deep exit ret_clr", 32'(ret_clr), 1);
    leave_and_clear();
    mode_sel = 3; try_enter(0);
    chk("R12 deep exit wiped pu", 32'(pad_pu), 0);
    chk("R12 deep exit wiped pd", 32'(pad_pd), 0);
    leave_and_clear();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule